// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Aggregator

This block collects thirty-two interrupt request lines and reduces them to two processor-facing outputs, one critical and one non-critical. Each line is brought into the clock domain by a two-flop synchronizer. It is then qualified by a per-source sense mode (edge or level) and an active polarity, and recorded in a pending register. A per-source enable gates pending bits onto the outputs. A per-source class bit chooses which of the two outputs a source drives.

Software reaches the block through a small register slave: a word offset, a write strobe, a read strobe and 32-bit data in each direction. Software clears pending bits by writing ones to them. A level-sensed source whose line is still active cannot be cleared; it sets its pending bit again at once, even when disabled. A read-only view presents pending AND enable, so one read tells the handler whether anything enabled is waiting. Source numbering is reversed with respect to bit numbering: source n occupies bit 31-n of every per-source register.

Top module: `evt_router`

## Requirements
- R1: After reset the pending, enable, class and sense-mode registers read 0, the polarity register reads 0xFFFFFFFF, and both outputs are low.
- R2: Source n (input `src_in[n]`) maps to bit 31-n of every per-source register. Offsets: 0x0 pending, 0x2 enable, 0x3 class, 0x4 polarity, 0x5 sense mode, 0x6 masked pending. `reg_rdata` shows the addressed register while `reg_rd` is high, and 0 otherwise. Any other offset reads 0 and ignores writes.
- R3: A write to offset 0x0 clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: A sense-mode bit of 1 selects edge sensing and 0 selects level sensing. A polarity bit of 1 means rising edge or high level, and 0 means falling edge or low level. An edge sets the pending bit, which stays set after the line returns inactive. A polarity change on its own creates no edge.
- R5: While a level-sensed line is at its active level, its pending bit is set, and a clear write leaves it set.
- R6: Offset 0x6 reads pending AND enable, and writes to it have no effect.
- R7: The non-critical output is the OR of masked pending bits whose class bit is 0. The critical output is the OR of masked pending bits whose class bit is 1. Both outputs are registered, one cycle after the masked value.
- R8: A pending bit is set by its source regardless of the enable bit. Clearing enable drops the outputs but keeps the pending bits.
- R9: When a new event and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R10: A change on `src_in` is visible in the pending register after the third rising clock edge following it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt lines, index = source number |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data valid in the same cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when no read is strobed |
| irq_noncrit | output | 1 | Registered non-critical request |
| irq_crit | output | 1 | Registered critical request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high together and that each strobe refers to the offset presented in the same cycle. They also assume that an edge event depends only on a change of the synchronized sample, so a polarity rewrite must not look like a transition. The stimulus changes inputs only just after a rising edge, issues one register access per cycle, and rewrites polarity only while the affected lines are steady. The same-cycle clear collision is timed exactly from the three-edge input latency.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;

    parameter int unsigned NSRC = 32;
    parameter int unsigned AW   = 4;

    typedef logic [NSRC-1:0] src_vec_t;

    // Word offsets of the register slave; software decodes these.
    typedef enum logic [AW-1:0] {
        OFS_PEND  = 4'h0,
        OFS_EN    = 4'h2,
        OFS_CLASS = 4'h3,
        OFS_POL   = 4'h4,
        OFS_MODE  = 4'h5,
        OFS_MPEND = 4'h6
    } reg_ofs_e;

endpackage

// File: rtl/evt_sync_detect.sv
// Synchronizes each interrupt line and turns it into a per-cycle set request.
// Assumes: src_in is indexed by source number; pol and mode are in register
// (bit-reversed) order, so source i lands on bit N-1-i of set_vec.
module evt_sync_detect #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] mode,
    output logic [N-1:0] set_vec
);
    logic [N-1:0] smp;
    logic [N-1:0] prv;
    logic [N-1:0] act_now;
    logic [N-1:0] act_old;
    logic [N-1:0] edge_hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        localparam int unsigned BIT = N - 1 - i;
        logic [STAGES-1:0] chain;
        logic              last;

        // Synchronizer chain plus one extra flop for the previous sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], src_in[i]};
                last  <= chain[STAGES-1];
            end
        end

        assign smp[BIT] = chain[STAGES-1];
        assign prv[BIT] = last;
    end

    // Apply polarity to both samples, then pick edge or level per source.
    always_comb begin
        act_now  = ~(smp ^ pol);
        act_old  = ~(prv ^ pol);
        edge_hit = act_now & ~act_old;
        set_vec  = (mode & edge_hit) | (~mode & act_now);
    end

    // An edge request only appears where the synchronized sample moved.
    p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode & edge_hit) != '0) |-> (((mode & edge_hit) & ~(smp ^ $past(smp))) == '0));

endmodule

// File: rtl/evt_status_bank.sv
// Pending register: set by source requests, cleared by write-one-to-clear.
// Assumes: clr_vec is already qualified by the write strobe and offset.
module evt_status_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);
    // Clear first, then set, so a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((pend & $past(clr_vec & ~set_vec)) == '0));

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && clr_vec == '0) |=> $stable(pend));

endmodule

// File: rtl/evt_out_stage.sv
// Masks pending bits with enable and drives the two registered outputs.
// Assumes: class bit 1 selects the critical output.
module evt_out_stage #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] cls,
    output logic [N-1:0] masked,
    output logic         irq_noncrit,
    output logic         irq_crit
);
    // Enabled pending view.
    always_comb masked = pend & enable;

    // Per-class reduction, registered once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_noncrit <= 1'b0;
            irq_crit    <= 1'b0;
        end else begin
            irq_noncrit <= |(masked & ~cls);
            irq_crit    <= |(masked & cls);
        end
    end

    p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> (!irq_noncrit && !irq_crit));

    p_pin_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_noncrit && !irq_crit));

endmodule

// File: rtl/evt_router.sv
// Top: configuration registers, register slave decode, and the three stages.
// Assumes: at most one of reg_wr / reg_rd per cycle; read data is combinational.
module evt_router
    import evt_router_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_noncrit,
    output logic            irq_crit
);
    src_vec_t en_q, cls_q, pol_q, mode_q;
    src_vec_t set_vec, clr_vec, pend, masked;

    // Configuration registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            cls_q  <= '0;
            pol_q  <= '1;
            mode_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_EN:    en_q   <= reg_wdata;
                OFS_CLASS: cls_q  <= reg_wdata;
                OFS_POL:   pol_q  <= reg_wdata;
                OFS_MODE:  mode_q <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Clear request for the pending bank.
    always_comb clr_vec = (reg_wr && reg_addr == OFS_PEND) ? reg_wdata : '0;

    // Read multiplexer, quiet when no read is strobed.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_PEND:  reg_rdata = pend;
                OFS_EN:    reg_rdata = en_q;
                OFS_CLASS: reg_rdata = cls_q;
                OFS_POL:   reg_rdata = pol_q;
                OFS_MODE:  reg_rdata = mode_q;
                OFS_MPEND: reg_rdata = masked;
                default:   reg_rdata = '0;
            endcase
        end
    end

    evt_sync_detect #(.N(NSRC), .STAGES(2)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .pol     (pol_q),
        .mode    (mode_q),
        .set_vec (set_vec)
    );

    evt_status_bank #(.N(NSRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    evt_out_stage #(.N(NSRC)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .enable      (en_q),
        .cls         (cls_q),
        .masked      (masked),
        .irq_noncrit (irq_noncrit),
        .irq_crit    (irq_crit)
    );

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr) |=> ($stable(en_q) && $stable(cls_q) && $stable(pol_q) && $stable(mode_q)));

    p_no_dual_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

endmodule

// File: tb/evt_router_test.sv
module evt_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_noncrit, irq_crit;

    logic        pin_chk = 1'b0;
    logic        done = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    evt_router uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_noncrit(irq_noncrit), .irq_crit(irq_crit)
    );

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Expected pins packed as {crit, noncrit}.
    task automatic pins(input logic c, input logic nc, input string t);
        exp_q.push_back({30'b0, c, nc}); tag_q.push_back(t);
        pin_chk = 1'b1;
        @(posedge clk); #1;
        pin_chk = 1'b0;
    endtask

    // Monitor: pop an expected item whenever a read or pin check is active.
    always @(negedge clk) begin
        if ((reg_rd || pin_chk) && exp_q.size() > 0) begin
            logic [31:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = reg_rd ? reg_rdata : {30'b0, irq_crit, irq_noncrit};
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd(4'h0, 32'h0, "R1 pending");
        rd(4'h2, 32'h0, "R1 enable");
        rd(4'h3, 32'h0, "R1 class");
        rd(4'h4, 32'hFFFF_FFFF, "R1 polarity");
        rd(4'h5, 32'h0, "R1 mode");
        pins(1'b0, 1'b0, "R1 outputs");

        // R5 level source 3 -> bit 28, enabled, non-critical
        wr(4'h2, 32'h1000_0000);
        src_in[3] = 1'b1;
        idle(4);
        rd(4'h0, 32'h1000_0000, "R5 level pending");
        rd(4'h6, 32'h1000_0000, "R6 masked view");
        pins(1'b0, 1'b1, "R7 non-critical route");
        wr(4'h0, 32'h1000_0000);
        idle(1);
        rd(4'h0, 32'h1000_0000, "R5 clear while active");
        src_in[3] = 1'b0;
        idle(4);
        wr(4'h0, 32'h1000_0000);
        idle(2);
        rd(4'h0, 32'h0, "R3 clear after release");
        pins(1'b0, 1'b0, "R7 outputs drop");

        // R4 rising edge source 0 -> bit 31, critical
        wr(4'h5, 32'h8000_0000);
        wr(4'h3, 32'h8000_0000);
        wr(4'h2, 32'h9000_0000);
        src_in[0] = 1'b1;
        idle(3);
        src_in[0] = 1'b0;
        idle(5);
        rd(4'h0, 32'h8000_0000, "R4 edge latched");
        pins(1'b1, 1'b0, "R7 critical route");
        wr(4'h0, 32'h8000_0000);
        idle(2);
        rd(4'h0, 32'h0, "R3 edge clear");

        // R4 falling edge source 31 -> bit 0
        wr(4'h5, 32'h8000_0001);
        wr(4'h4, 32'hFFFF_FFFE);
        idle(3);
        rd(4'h0, 32'h0, "R4 polarity change no event");
        src_in[31] = 1'b1;
        idle(5);
        rd(4'h0, 32'h0, "R4 rising ignored when falling");
        src_in[31] = 1'b0;
        idle(5);
        rd(4'h0, 32'h0000_0001, "R4 falling edge");
        wr(4'h0, 32'h0000_0001);

        // R8 disabled level source 10 -> bit 21
        src_in[10] = 1'b1;
        idle(4);
        rd(4'h0, 32'h0020_0000, "R8 pending while disabled");
        rd(4'h6, 32'h0, "R8 masked hides disabled");
        pins(1'b0, 1'b0, "R8 no output when disabled");
        src_in[10] = 1'b0;
        idle(4);
        wr(4'h0, 32'h0020_0000);

        // R6 masked view ignores writes; R2 unused offset
        src_in[3] = 1'b1;
        idle(4);
        wr(4'h6, 32'h0);
        rd(4'h6, 32'h1000_0000, "R6 write ignored");
        wr(4'h7, 32'hFFFF_FFFF);
        rd(4'h7, 32'h0, "R2 unused offset reads zero");
        rd(4'h2, 32'h9000_0000, "R2 enable readback");

        // R7 both outputs at once
        src_in[0] = 1'b1;
        idle(3);
        src_in[0] = 1'b0;
        idle(4);
        pins(1'b1, 1'b1, "R7 both classes");
        wr(4'h2, 32'h0);
        idle(2);
        pins(1'b0, 1'b0, "R8 enable cleared");
        rd(4'h0, 32'h9000_0000, "R8 pending kept");
        src_in[3] = 1'b0;
        idle(4);
        wr(4'h0, 32'hFFFF_FFFF);
        idle(2);
        rd(4'h0, 32'h0, "R3 clear all");

        // R9 edge event and clear in the same cycle, source 5 -> bit 26
        wr(4'h5, 32'h8400_0001);
        src_in[5] = 1'b1;
        idle(2);
        wr(4'h0, 32'h0400_0000);
        idle(2);
        rd(4'h0, 32'h0400_0000, "R9 event wins");
        wr(4'h0, 32'h0400_0000);
        idle(2);
        rd(4'h0, 32'h0, "R3 steady edge line stays clear");

        // R10 three-edge latency, level source 12 -> bit 19
        src_in[12] = 1'b1;
        idle(2);
        rd(4'h0, 32'h0, "R10 not after second edge");
        rd(4'h0, 32'h0008_0000, "R10 after third edge");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule